// File: doc/BRIEF.md
# Indexed Interrupt Routing Register Bank

This block holds the programmable state of an I/O interrupt controller: an identification register, a read-only version register, an arbitration register and a table of routing entries, one 64-bit entry per interrupt pin. Software reaches all of it through two 32-bit locations on a simple bus. The first is a selector register. The second is a data window that reads or writes whichever register the selector currently names.

Each 64-bit routing entry takes two selector values. One addresses the low word and the next addresses the high word. The entry carries the vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. Two status bits in the low word, delivery status and remote request, are not writable from the bus. A separate dispatch block reads any entry directly, without waiting for a clock, by presenting a pin number.

Top module: `irq_route_regs`

## Requirements
- R1: The selector register sits at bus offset 0x00. It is 32 bits wide, readable and writable, and resets to 0.
- R2: A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd` is sampled. `bus_rvalid` is low in the cycle after any cycle without a read.
- R3: Through the window at offset 0x10, selector value 1 reads the version word 0x00170011: bits 7:0 hold the version 0x11 and bits 23:16 hold the highest entry number, NUM_ENTRIES-1. A window write to it leaves the word unchanged and raises `bus_err`.
- R4: Selector value 0 is the identification register. Its 4-bit field is in bits 27:24 and resets to the ID_RESET parameter. Selector value 2 is the arbitration register. Its 4-bit field is in bits 27:24 and resets to 0. All other bits of both registers read 0.
- R5: Entry n is reached at selector 0x10+2n for its low word (bits 31:0) and at 0x11+2n for its high word (bits 63:32).
- R6: A write to a low word stores every bit except bit 12 (delivery status) and bit 14 (remote request), which keep their stored value. A write to a high word replaces all 32 bits.
- R7: At reset, every entry has low word 0x00010000 (mask bit 16 set, all else 0) and high word 0.
- R8: A window access whose entry number, (selector-0x10)>>1, is NUM_ENTRIES or more raises `bus_err`, leaves the table unchanged and reads 0.
- R9: Selector values 3 through 0x0F read 0 through the window, raise no error and store nothing.
- R10: `pin_entry` shows the full 64-bit entry chosen by `pin_sel` in the same cycle. It shows 0 when `pin_sel` is NUM_ENTRIES or more.
- R11: `bus_err` is a single-cycle pulse that appears in the cycle after the offending access. It stays low after every access not named in R3 or R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset: 0x00 selector, 0x10 window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Refused or out-of-range window access |
| pin_sel | input | PIN_W | Entry number requested by the dispatch block |
| pin_entry | output | 64 | Selected entry, combinational |

## Verification
The protected status bits are the hardest part to observe. No bus sequence can ever set them, so their protection shows up only as zeros that survive low-word writes of all ones. The bench writes such patterns to every entry and then reads each entry back through both the window and the dispatch port. The out-of-range path is reached with selectors just past the table and with selectors large enough that the subtraction wraps. After each of these, a full sweep shows that no entry was disturbed.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
   typedef enum logic [2:0] {
      SEL_ID, SEL_VER, SEL_ARB, SEL_ENTRY, SEL_NONE, SEL_BAD
   } sel_kind_e;

   // low-word bits that bus writes may not change (delivery status, remote request)
   localparam logic [31:0] LO_KEEP_MASK = 32'h0000_5000;
   localparam logic [63:0] ENTRY_RESET  = 64'h0000_0000_0001_0000;
   localparam int          FIELD_LSB    = 24;
   localparam int          FIELD_W      = 4;
endpackage

// File: rtl/irq_idx_decode.sv
module irq_idx_decode
   import irq_regs_pkg::*;
#(
   parameter int          NUM_ENTRIES = 24,
   parameter logic [31:0] REDIR_BASE  = 32'h10,
   parameter int          ENT_W       = 5
) (
   input  logic [31:0]      index,
   output sel_kind_e        kind,
   output logic [ENT_W-1:0] entry,
   output logic             hi
);
   logic [31:0] rem;
   assign rem = index - REDIR_BASE;
   assign hi  = rem[0];

   always_comb begin
      kind  = SEL_NONE;
      entry = '0;
      if (index == 32'd0)           kind = SEL_ID;
      else if (index == 32'd1)      kind = SEL_VER;
      else if (index == 32'd2)      kind = SEL_ARB;
      else if (index < REDIR_BASE)  kind = SEL_NONE;
      else if ((rem >> 1) >= 32'(NUM_ENTRIES)) kind = SEL_BAD;
      else begin
         kind  = SEL_ENTRY;
         entry = rem[ENT_W:1];
      end
   end
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
   import irq_regs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   output logic [63:0] value
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= ENTRY_RESET;
      end else begin
         if (wr_lo)
            value[31:0] <= (wdata & ~LO_KEEP_MASK) | (value[31:0] & LO_KEEP_MASK);
         if (wr_hi)
            value[63:32] <= wdata;
      end
   end
endmodule

// File: rtl/irq_entry_mux.sv
module irq_entry_mux #(
   parameter int NUM   = 24,
   parameter int SEL_W = 5
) (
   input  logic [NUM-1:0][63:0] entries,
   input  logic [SEL_W-1:0]     sel,
   output logic [63:0]          value
);
   always_comb begin
      value = '0;
      for (int i = 0; i < NUM; i++)
         if (32'(sel) == i) value = entries[i];
   end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_regs_pkg::*;
#(
   parameter int          NUM_ENTRIES = 24,
   parameter int          ADDR_W      = 5,
   parameter int          PIN_W       = 5,
   parameter logic [3:0]  ID_RESET    = 4'h0,
   parameter logic [7:0]  VERSION     = 8'h11,
   parameter logic [31:0] REDIR_BASE  = 32'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   output logic              bus_err,
   input  logic [PIN_W-1:0]  pin_sel,
   output logic [63:0]       pin_entry
);
   localparam int ENT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
   localparam logic [ADDR_W-1:0] OFS_INDEX  = '0;
   localparam logic [ADDR_W-1:0] OFS_WINDOW = ADDR_W'(16);
   localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 64) begin : g_bad_entries
      $error("NUM_ENTRIES must lie in 1..64");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x10");
   end
   if (PIN_W < ENT_W) begin : g_bad_pin
      $error("PIN_W too narrow for NUM_ENTRIES");
   end
   if (REDIR_BASE < 32'd3) begin : g_bad_base
      $error("REDIR_BASE overlaps fixed registers");
   end

   logic [31:0]         index_q;
   logic [FIELD_W-1:0]  id_q, arb_q;
   sel_kind_e           kind;
   logic [ENT_W-1:0]    ent_num;
   logic                ent_hi;
   logic                win_wr, win_rd;
   logic [NUM_ENTRIES-1:0][63:0] table_q;
   logic [63:0]         bus_entry;
   logic [31:0]         rd_word;

   assign win_wr = bus_wr && (bus_addr == OFS_WINDOW);
   assign win_rd = bus_rd && (bus_addr == OFS_WINDOW);

   irq_idx_decode #(
      .NUM_ENTRIES(NUM_ENTRIES), .REDIR_BASE(REDIR_BASE), .ENT_W(ENT_W)
   ) u_dec (
      .index(index_q), .kind(kind), .entry(ent_num), .hi(ent_hi)
   );

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
      logic sel_this;
      assign sel_this = win_wr && (kind == SEL_ENTRY) && (32'(ent_num) == g);
      irq_redir_entry u_ent (
         .clk(clk), .rst_n(rst_n),
         .wr_lo(sel_this && !ent_hi),
         .wr_hi(sel_this && ent_hi),
         .wdata(bus_wdata),
         .value(table_q[g])
      );
   end

   irq_entry_mux #(.NUM(NUM_ENTRIES), .SEL_W(ENT_W)) u_bus_mux (
      .entries(table_q), .sel(ent_num), .value(bus_entry)
   );

   irq_entry_mux #(.NUM(NUM_ENTRIES), .SEL_W(PIN_W)) u_pin_mux (
      .entries(table_q), .sel(pin_sel), .value(pin_entry)
   );

   always_comb begin
      rd_word = '0;
      if (bus_addr == OFS_INDEX) begin
         rd_word = index_q;
      end else if (bus_addr == OFS_WINDOW) begin
         case (kind)
            SEL_ID:    rd_word[FIELD_LSB +: FIELD_W] = id_q;
            SEL_VER:   rd_word = VER_WORD;
            SEL_ARB:   rd_word[FIELD_LSB +: FIELD_W] = arb_q;
            SEL_ENTRY: rd_word = ent_hi ? bus_entry[63:32] : bus_entry[31:0];
            default:   rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q    <= '0;
         id_q       <= ID_RESET;
         arb_q      <= '0;
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
         bus_err    <= 1'b0;
      end else begin
         bus_rvalid <= bus_rd;
         if (bus_rd) bus_rdata <= rd_word;
         bus_err <= ((win_rd || win_wr) && (kind == SEL_BAD)) ||
                    (win_wr && (kind == SEL_VER));
         if (bus_wr && (bus_addr == OFS_INDEX)) index_q <= bus_wdata;
         if (win_wr && (kind == SEL_ID))  id_q  <= bus_wdata[FIELD_LSB +: FIELD_W];
         if (win_wr && (kind == SEL_ARB)) arb_q <= bus_wdata[FIELD_LSB +: FIELD_W];
      end
   end
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
   parameter int         NUM_ENTRIES = 24,
   parameter int         ADDR_W      = 5,
   parameter int         PIN_W       = 5,
   parameter logic [7:0] VERSION     = 8'h11
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [31:0]       bus_rdata,
   input logic              bus_rvalid,
   input logic              bus_err,
   input logic [PIN_W-1:0]  pin_sel,
   input logic [63:0]       pin_entry,
   input logic [31:0]       index_q
);
   localparam logic [ADDR_W-1:0] WIN = ADDR_W'(16);
   localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

   a_r2_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_rvalid);
   a_r3_ver_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == WIN && index_q == 32'd1) |=> (bus_rdata == VER_WORD));
   a_r3_ver_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == WIN && index_q == 32'd1) |=> bus_err);
   a_r6_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(pin_sel) < NUM_ENTRIES) |-> (!pin_entry[12] && !pin_entry[14]));
   a_r10_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(pin_sel) >= NUM_ENTRIES) |-> (pin_entry == 64'd0));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(pin_sel) && !$past(bus_wr)) |-> $stable(pin_entry));
   a_r11_index_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_rd && bus_addr == '0) |=> !bus_err);
endmodule

bind irq_route_regs irq_route_regs_chk #(
   .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .PIN_W(PIN_W), .VERSION(VERSION)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
   .bus_err(bus_err), .pin_sel(pin_sel), .pin_entry(pin_entry),
   .index_q(index_q)
);

// File: tb/tb_irq_route_regs.sv
module tb_irq_route_regs;
   localparam int CLK_PERIOD = 10;
   localparam int N = 24;
   localparam logic [3:0] IDR = 4'h9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid, bus_err;
   logic [4:0]  pin_sel = '0;
   logic [63:0] pin_entry;

   int tests = 0, fails = 0;
   logic [31:0] exp_lo [N];
   logic [31:0] exp_hi [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_route_regs #(.ID_RESET(IDR)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .bus_err(bus_err), .pin_sel(pin_sel),
      .pin_entry(pin_entry)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bwrite(input logic [4:0] a, input logic [31:0] d, output logic e);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      e = bus_err;
   endtask

   task automatic bread(input logic [4:0] a, output logic [31:0] d, output logic e, output logic v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata; e = bus_err; v = bus_rvalid;
   endtask

   task automatic win_write(input logic [31:0] idx, input logic [31:0] d, output logic e);
      logic e0;
      bwrite(5'h00, idx, e0);
      bwrite(5'h10, d, e);
   endtask

   task automatic win_read(input logic [31:0] idx, output logic [31:0] d, output logic e);
      logic e0, v;
      bwrite(5'h00, idx, e0);
      bread(5'h10, d, e, v);
   endtask

   task automatic sweep(input string tag);
      logic [31:0] d; logic e;
      for (int n = 0; n < N; n++) begin
         win_read(32'h10 + 2*n, d, e);
         check(d == exp_lo[n] && !e, {tag, " lo R5"}, d, exp_lo[n]);
         win_read(32'h11 + 2*n, d, e);
         check(d == exp_hi[n] && !e, {tag, " hi R5"}, d, exp_hi[n]);
         @(negedge clk); pin_sel = 5'(n); #1;
         check(pin_entry == {exp_hi[n], exp_lo[n]}, {tag, " pin R10"},
               pin_entry, {exp_hi[n], exp_lo[n]});
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] d; logic e, v;
      for (int n = 0; n < N; n++) begin
         exp_lo[n] = 32'h0001_0000;
         exp_hi[n] = 32'h0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      bread(5'h00, d, e, v);
      check(d == 0 && v, "R1 index reset", d, 0);
      check(v == 1'b1, "R2 rvalid after read", v, 1);
      @(negedge clk);
      check(bus_rvalid == 1'b0, "R2 rvalid idle", bus_rvalid, 0);
      win_read(32'd0, d, e);
      check(d == {4'h0, IDR, 24'h0}, "R4 id reset", d, {4'h0, IDR, 24'h0});
      win_read(32'd1, d, e);
      check(d == 32'h0017_0011, "R3 version", d, 32'h0017_0011);
      win_read(32'd2, d, e);
      check(d == 0, "R4 arb reset", d, 0);
      sweep("R7 reset");

      // id / arb fields
      win_write(32'd0, 32'hFFFF_FFFF, e);
      check(!e, "R11 id write no err", e, 0);
      win_read(32'd0, d, e);
      check(d == 32'h0F00_0000, "R4 id field", d, 32'h0F00_0000);
      win_write(32'd2, 32'hA5A5_A5A5, e);
      win_read(32'd2, d, e);
      check(d == 32'h0500_0000, "R4 arb field", d, 32'h0500_0000);

      // version refused
      win_write(32'd1, 32'h0, e);
      check(e, "R3 version write err", e, 1);
      @(negedge clk);
      check(!bus_err, "R11 err one cycle", bus_err, 0);
      win_read(32'd1, d, e);
      check(d == 32'h0017_0011 && !e, "R3 version kept", d, 32'h0017_0011);

      // program every entry with distinct patterns
      for (int n = 0; n < N; n++) begin
         logic [31:0] lo, hi;
         lo = 32'hFFFF_FFFF ^ (32'(n) * 32'h0101_0037);
         hi = 32'hC000_0000 | (32'(n) * 32'h0100_0103);
         win_write(32'h10 + 2*n, lo, e);
         check(!e, "R11 lo write no err", e, 0);
         win_write(32'h11 + 2*n, hi, e);
         check(!e, "R11 hi write no err", e, 0);
         exp_lo[n] = lo & ~32'h0000_5000;
         exp_hi[n] = hi;
      end
      sweep("R6 programmed");
      win_write(32'h10, 32'hFFFF_FFFF, e);
      exp_lo[0] = 32'hFFFF_AFFF;
      win_read(32'h10, d, e);
      check(d == 32'hFFFF_AFFF, "R6 status bits kept", d, 32'hFFFF_AFFF);

      // out-of-range entries
      win_write(32'h10 + 2*N, 32'hFFFF_FFFF, e);
      check(e, "R8 oor lo write err", e, 1);
      win_write(32'h11 + 2*N, 32'hFFFF_FFFF, e);
      check(e, "R8 oor hi write err", e, 1);
      win_write(32'hFFFF_FFFF, 32'h1234_5678, e);
      check(e, "R8 wrap write err", e, 1);
      win_read(32'h10 + 2*N, d, e);
      check(d == 0 && e, "R8 oor read", d, 0);
      win_read(32'h8000_0010, d, e);
      check(d == 0 && e, "R8 far read", d, 0);

      // unimplemented selectors
      for (int i = 3; i < 16; i++) begin
         win_write(32'(i), 32'hFFFF_FFFF, e);
         check(!e, "R9 unimpl write no err", e, 0);
         win_read(32'(i), d, e);
         check(d == 0 && !e, "R9 unimpl read zero", d, 0);
      end
      win_read(32'd0, d, e);
      check(d == 32'h0F00_0000, "R9 id untouched", d, 32'h0F00_0000);
      sweep("R8 R9 table untouched");

      // dispatch port beyond the table
      for (int p = N; p < 32; p++) begin
         @(negedge clk); pin_sel = 5'(p); #1;
         check(pin_entry == 64'd0, "R10 pin oor zero", pin_entry, 0);
      end

      // selector readback
      bwrite(5'h00, 32'hDEAD_BEEF, e);
      check(!e, "R11 index write no err", e, 0);
      bread(5'h00, d, e, v);
      check(d == 32'hDEAD_BEEF && v, "R1 index readback", d, 32'hDEAD_BEEF);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule